// File: doc/BRIEF.md
# GPIO Bank with Atomic Set/Clear Aliases

The block is a bank of sixteen general-purpose pins on a simple register bus. Software drives pin outputs, picks pin directions and arms edge-triggered interrupts. The output register, the interrupt-enable register and the wake-enable register each have two extra alias addresses. Writing ones to the set alias turns those bits on, and writing ones to the clear alias turns them off. Bits written as zero keep their value, so a single bus write updates one pin and never needs a read-modify-write sequence.

Each pin has a two-bit edge-mode field that arms rising, falling, both or no edges. The fields for the lower half of the bank sit in one control register and the fields for the upper half in a second one. The pin inputs pass through a two-stage synchronizer before edge detection. A detected edge sets a sticky status bit, which software clears by writing ones. A registered interrupt output reports any status bit whose interrupt is enabled, and a registered wake output reports any status bit whose wake request is enabled. A read-only revision word and a pair of system registers complete the map.

Top module: `pinbank_ctrl`

## Requirements
- R1: After a synchronous reset, pin_out is 0x0000, pin_dir is 0xFFFF (all pins inputs), irq_out and wake_out are 0, and the status, enable and edge-mode registers read 0x0000.
- R2: Offset 0x00 reads the revision word, with the major number in bits 7:4 and the minor number in bits 3:0 (0x0021 by default). Writes to it have no effect.
- R3: Offset 0x30 holds the output word driven on pin_out, and a write there replaces it. Ones written to 0xF0 set the matching output bits and ones written to 0xB0 clear them. Zero bits in either alias leave their output bit unchanged.
- R4: Offset 0x1C holds the interrupt-enable word (1 = enabled), and a write there replaces it. Ones written to 0xDC set enable bits and ones written to 0x9C clear them. Zero bits leave the enable unchanged.
- R5: Offset 0x28 holds the wake-enable word, and a write there replaces it. Ones written to 0xE8 set wake-enable bits and ones written to 0xA8 clear them. Zero bits leave the enable unchanged.
- R6: Pin p has a two-bit edge field at bits [2*(p mod 8)+1 : 2*(p mod 8)]. For pins 0-7 the field is in the register at 0x38, and for pins 8-15 it is in the register at 0x3C. In the field, bit 1 arms rising-edge detection and bit 0 arms falling-edge detection, so 3 detects both edges and 0 detects none. A detected edge sets status bit p on the third rising clock edge after the pin changes.
- R7: Offset 0x18 holds the sticky status word. Writing a 1 clears that bit and writing a 0 leaves it unchanged. A bit changes to 0 only through such a write. If a new edge arrives on the same clock edge as a clear of its bit, the bit stays set.
- R8: irq_out is the OR over all pins of (status AND interrupt-enable), registered one clock after the status and enable words.
- R9: wake_out is the OR over all pins of (status AND wake-enable), registered one clock after the status and wake-enable words.
- R10: Offset 0x34 holds the direction word, where 1 means input, and drives pin_dir. Offset 0x2C reads the synchronized pin_in levels, two clocks behind pin_in.
- R11: Read data appears on reg_rdata on the clock after the read request and holds until the next read. Offset 0x10 is a read/write configuration word, and offset 0x14 reads 0x0001 (reset done). Any other address, including the six set/clear aliases, reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Bus access request for this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read (when reg_en is high) |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output word for the pins |
| pin_dir | output | 16 | Direction per pin, 1 = input |
| irq_out | output | 1 | Interrupt request |
| wake_out | output | 1 | Wake-up request |

## Verification
A write takes effect on the clock edge that samples it, so the bench checks pin_out and pin_dir at the following falling edge. irq_out and wake_out follow one clock later, so the bench waits one more cycle before checking them. A read returns data one clock after the request, and the bench samples reg_rdata at the falling edge after the capturing clock edge. A pin change sets its status bit on the third clock edge and raises irq_out on the fourth. The bench holds each pin change for four cycles before it reads status. In one directed case it checks irq_out low at the third falling edge and high at the fourth, and in another it times a status clear to land on the same edge as a new detection.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int ADDR_W = 8;

  // Register offsets (software-visible map)
  localparam logic [ADDR_W-1:0] OFS_REV      = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SYSCFG   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SYSSTAT  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_STAT     = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IEN      = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_WEN      = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_DIN      = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_DOUT     = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_DIR      = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_EMODE_LO = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_EMODE_HI = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_IEN_CLR  = 8'h9C;
  localparam logic [ADDR_W-1:0] OFS_WEN_CLR  = 8'hA8;
  localparam logic [ADDR_W-1:0] OFS_DOUT_CLR = 8'hB0;
  localparam logic [ADDR_W-1:0] OFS_IEN_SET  = 8'hDC;
  localparam logic [ADDR_W-1:0] OFS_WEN_SET  = 8'hE8;
  localparam logic [ADDR_W-1:0] OFS_DOUT_SET = 8'hF0;

  // Bit positions inside a two-bit edge field
  localparam int RISE_BIT = 1;
  localparam int FALL_BIT = 0;

  typedef enum logic [1:0] {
    UPD_KEEP,
    UPD_LOAD,
    UPD_SET,
    UPD_CLR
  } upd_op_e;

  function automatic logic [15:0] apply_upd(input logic [15:0] cur,
                                            input logic [15:0] val,
                                            input upd_op_e op);
    case (op)
      UPD_LOAD: return val;
      UPD_SET:  return cur | val;
      UPD_CLR:  return cur & ~val;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pinbank_edge.sv
module pinbank_edge
  import pinbank_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] level,
  input  logic [PINS-1:0] mode_lo,
  input  logic [PINS-1:0] mode_hi,
  output logic [PINS-1:0] hit
);
  localparam int HALF = PINS / 2;

  logic [PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    localparam int SLOT = p % HALF;
    logic [1:0] fld;
    if (p < HALF) begin : g_lo
      assign fld = mode_lo[2*SLOT +: 2];
    end else begin : g_hi
      assign fld = mode_hi[2*SLOT +: 2];
    end
    assign hit[p] = (fld[RISE_BIT] &  level[p] & ~prev_q[p]) |
                    (fld[FALL_BIT] & ~level[p] &  prev_q[p]);
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int PINS      = 16,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PINS-1:0]   reg_wdata,
  output logic [PINS-1:0]   reg_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_dir,
  output logic              irq_out,
  output logic              wake_out
);
  localparam logic [PINS-1:0] REV_WORD  = PINS'({4'(REV_MAJOR), 4'(REV_MINOR)});
  localparam logic [PINS-1:0] DONE_WORD = PINS'(1);

  logic [PINS-1:0] dout_q, dir_q, ien_q, wen_q, stat_q, sysc_q;
  logic [PINS-1:0] emode_lo_q, emode_hi_q;
  logic [PINS-1:0] pin_sync, hit, clr_mask, rd_mux;
  logic            wr_req, rd_req;
  upd_op_e         dout_op, ien_op, wen_op;

  assign wr_req = reg_en &  reg_wr;
  assign rd_req = reg_en & ~reg_wr;

  pinbank_sync #(.W(PINS), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  pinbank_edge #(.PINS(PINS)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .level   (pin_sync),
    .mode_lo (emode_lo_q),
    .mode_hi (emode_hi_q),
    .hit     (hit)
  );

  // Decode of the three alias families
  always_comb begin
    dout_op = UPD_KEEP;
    ien_op  = UPD_KEEP;
    wen_op  = UPD_KEEP;
    if (wr_req) begin
      case (reg_addr)
        OFS_DOUT:     dout_op = UPD_LOAD;
        OFS_DOUT_SET: dout_op = UPD_SET;
        OFS_DOUT_CLR: dout_op = UPD_CLR;
        OFS_IEN:      ien_op  = UPD_LOAD;
        OFS_IEN_SET:  ien_op  = UPD_SET;
        OFS_IEN_CLR:  ien_op  = UPD_CLR;
        OFS_WEN:      wen_op  = UPD_LOAD;
        OFS_WEN_SET:  wen_op  = UPD_SET;
        OFS_WEN_CLR:  wen_op  = UPD_CLR;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      ien_q  <= '0;
      wen_q  <= '0;
    end else begin
      dout_q <= apply_upd(dout_q, reg_wdata, dout_op);
      ien_q  <= apply_upd(ien_q,  reg_wdata, ien_op);
      wen_q  <= apply_upd(wen_q,  reg_wdata, wen_op);
    end
  end

  // Plain read/write control words
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q      <= '1;
      emode_lo_q <= '0;
      emode_hi_q <= '0;
      sysc_q     <= '0;
    end else if (wr_req) begin
      case (reg_addr)
        OFS_DIR:      dir_q      <= reg_wdata;
        OFS_EMODE_LO: emode_lo_q <= reg_wdata;
        OFS_EMODE_HI: emode_hi_q <= reg_wdata;
        OFS_SYSCFG:   sysc_q     <= reg_wdata;
        default: ;
      endcase
    end
  end

  // Sticky status: a fresh edge outranks a clear on the same edge
  assign clr_mask = (wr_req && reg_addr == OFS_STAT) ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out  <= 1'b0;
      wake_out <= 1'b0;
    end else begin
      irq_out  <= |(stat_q & ien_q);
      wake_out <= |(stat_q & wen_q);
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_REV:      rd_mux = REV_WORD;
      OFS_SYSCFG:   rd_mux = sysc_q;
      OFS_SYSSTAT:  rd_mux = DONE_WORD;
      OFS_STAT:     rd_mux = stat_q;
      OFS_IEN:      rd_mux = ien_q;
      OFS_WEN:      rd_mux = wen_q;
      OFS_DIN:      rd_mux = pin_sync;
      OFS_DOUT:     rd_mux = dout_q;
      OFS_DIR:      rd_mux = dir_q;
      OFS_EMODE_LO: rd_mux = emode_lo_q;
      OFS_EMODE_HI: rd_mux = emode_hi_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (rd_req) reg_rdata <= rd_mux;
  end

  assign pin_out = dout_q;
  assign pin_dir = dir_q;
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
  import pinbank_pkg::*;
#(
  parameter int PINS      = 16,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_en,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [PINS-1:0]   reg_wdata,
  input logic [PINS-1:0]   reg_rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_dir,
  input logic              irq_out,
  input logic              wake_out,
  input logic [PINS-1:0]   ien,
  input logic [PINS-1:0]   wen,
  input logic [PINS-1:0]   stat
);
  localparam logic [PINS-1:0] REV_WORD = PINS'({4'(REV_MAJOR), 4'(REV_MINOR)});

  logic wr_req, rd_req;
  assign wr_req = reg_en &  reg_wr;
  assign rd_req = reg_en & ~reg_wr;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_out && !wake_out && pin_out == '0 && pin_dir == '1)); // R1

  AST_REV_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_req && reg_addr == OFS_REV) |=> reg_rdata == REV_WORD); // R2

  AST_DOUT_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_req && reg_addr == OFS_DOUT_SET) |=> pin_out == ($past(pin_out) | $past(reg_wdata))); // R3

  AST_DOUT_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_req && reg_addr == OFS_DOUT_CLR) |=> pin_out == ($past(pin_out) & ~$past(reg_wdata))); // R3

  AST_IEN_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_req && reg_addr == OFS_IEN_SET) |=> ien == ($past(ien) | $past(reg_wdata))); // R4

  AST_WEN_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_req && reg_addr == OFS_WEN_CLR) |=> wen == ($past(wen) & ~$past(reg_wdata))); // R5

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && reg_addr == OFS_STAT) |=> (($past(stat) & ~stat) == '0)); // R7

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    (|(stat & ien)) |=> irq_out); // R8

  AST_WAKE_LAG: assert property (@(posedge clk) disable iff (rst)
    ((stat & wen) == '0) |=> !wake_out); // R9

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && reg_addr == OFS_DIR) |=> $stable(pin_dir)); // R10

  AST_DONE_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_req && reg_addr == OFS_SYSSTAT) |=> reg_rdata == PINS'(1)); // R11

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(reg_rdata)); // R11
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
  .PINS(PINS), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_en    (reg_en),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pin_out   (pin_out),
  .pin_dir   (pin_dir),
  .irq_out   (irq_out),
  .wake_out  (wake_out),
  .ien       (ien_q),
  .wen       (wen_q),
  .stat      (stat_q)
);

// File: tb/pinbank_ctrl_test.sv
`timescale 1ns/1ps
module pinbank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_en = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [15:0] pin_in = '0, pin_out, pin_dir;
  logic        irq_out, wake_out;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // Reference model state
  logic [15:0] m_dout = '0, m_dir = '1, m_ien = '0, m_wen = '0, m_stat = '0;
  logic [15:0] m_elo = '0, m_ehi = '0, m_sysc = '0, m_pins = '0;

  pinbank_ctrl uut (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_dir(pin_dir),
    .irq_out(irq_out), .wake_out(wake_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return 16'h0021;
      8'h10: return m_sysc;
      8'h14: return 16'h0001;
      8'h18: return m_stat;
      8'h1C: return m_ien;
      8'h28: return m_wen;
      8'h2C: return m_pins;
      8'h30: return m_dout;
      8'h34: return m_dir;
      8'h38: return m_elo;
      8'h3C: return m_ehi;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] edge_hits(input logic [15:0] oldv, input logic [15:0] newv);
    logic [15:0] h = '0;
    for (int p = 0; p < 16; p++) begin
      logic [1:0] f;
      f = (p < 8) ? m_elo[2*(p%8) +: 2] : m_ehi[2*(p%8) +: 2];
      h[p] = (f[1] & ~oldv[p] & newv[p]) | (f[0] & oldv[p] & ~newv[p]);
    end
    return h;
  endfunction

  task automatic mdl_write(input logic [7:0] a, input logic [15:0] d);
    case (a)
      8'h30: m_dout = d;
      8'hF0: m_dout = m_dout | d;
      8'hB0: m_dout = m_dout & ~d;
      8'h1C: m_ien = d;
      8'hDC: m_ien = m_ien | d;
      8'h9C: m_ien = m_ien & ~d;
      8'h28: m_wen = d;
      8'hE8: m_wen = m_wen | d;
      8'hA8: m_wen = m_wen & ~d;
      8'h34: m_dir = d;
      8'h38: m_elo = d;
      8'h3C: m_ehi = d;
      8'h10: m_sysc = d;
      8'h18: m_stat = m_stat & ~d;
      default: ;
    endcase
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0;
    mdl_write(a, d);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a);
    logic [15:0] v;
    bus_rd(a, v);
    chk(tag, v, exp_read(a));
  endtask

  // Drive new pin levels and let detection, status and outputs settle
  task automatic pin_step(input logic [15:0] v);
    logic [15:0] h;
    h = edge_hits(m_pins, v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
    m_stat = m_stat | h;
    m_pins = v;
  endtask

  task automatic port_chk(input string tag);
    chk({tag, " pin_out"}, pin_out, m_dout);
    chk({tag, " pin_dir"}, pin_dir, m_dir);
    chk({tag, " irq_out"}, {15'd0, irq_out},  {15'd0, |(m_stat & m_ien)});
    chk({tag, " wake_out"}, {15'd0, wake_out}, {15'd0, |(m_stat & m_wen)});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] wr_addrs [15] = '{8'h30, 8'hF0, 8'hB0, 8'h1C, 8'hDC, 8'h9C, 8'h28,
                                  8'hE8, 8'hA8, 8'h34, 8'h38, 8'h3C, 8'h18, 8'h10, 8'h00};
    logic [7:0] rd_addrs [14] = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h28, 8'h2C,
                                  8'h30, 8'h34, 8'h38, 8'h3C, 8'h44, 8'hF0, 8'h9C};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    port_chk("R1 reset");
    rd_chk("R1 reset status", 8'h18);
    rd_chk("R1 reset edge mode", 8'h38);
    // R2 revision, writes ignored
    rd_chk("R2 revision", 8'h00);
    bus_wr(8'h00, 16'hFFFF);
    rd_chk("R2 revision after write", 8'h00);

    // R3 output aliases
    bus_wr(8'h30, 16'hA5A5);
    chk("R3 direct load", pin_out, 16'hA5A5);
    bus_wr(8'hF0, 16'h0F00);
    chk("R3 set alias", pin_out, 16'hAFA5);
    bus_wr(8'hB0, 16'h0005);
    chk("R3 clear alias", pin_out, 16'hAFA0);

    // R4 / R5 enable aliases
    bus_wr(8'hDC, 16'h0108);
    bus_wr(8'h9C, 16'h0100);
    rd_chk("R4 ien set/clear", 8'h1C);
    bus_wr(8'hE8, 16'h1001);
    bus_wr(8'hA8, 16'h0001);
    rd_chk("R5 wen set/clear", 8'h28);

    // R6 + R8: pin 3 rising only, interrupt timing
    bus_wr(8'h38, 16'h0080);
    @(negedge clk);
    pin_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 irq not yet at third edge", {15'd0, irq_out}, 16'd0);
    @(negedge clk);
    chk("R8 irq at fourth edge", {15'd0, irq_out}, 16'd1);
    m_pins[3] = 1'b1; m_stat[3] = 1'b1;
    rd_chk("R6 rising sets status", 8'h18);
    bus_wr(8'h18, 16'h0008);
    pin_step(16'h0000);
    rd_chk("R6 falling ignored in rise-only mode", 8'h18);

    // R6 + R9: pin 12 falling only, wake path
    bus_wr(8'h3C, 16'h0100);
    pin_step(16'h1000);
    rd_chk("R6 rising ignored in fall-only mode", 8'h18);
    pin_step(16'h0000);
    rd_chk("R6 falling on upper half", 8'h18);
    @(negedge clk);
    chk("R9 wake raised", {15'd0, wake_out}, 16'd1);
    bus_wr(8'h18, 16'h0000);
    rd_chk("R7 zero write keeps status", 8'h18);
    bus_wr(8'h18, 16'h1000);
    @(negedge clk);
    chk("R9 wake dropped after clear", {15'd0, wake_out}, 16'd0);

    // R7: clear and new edge on the same clock edge
    bus_wr(8'h38, 16'h00C0);
    pin_step(16'h0008);
    @(negedge clk);
    pin_in = 16'h0000;
    @(negedge clk);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 8'h18; reg_wdata = 16'h0008;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0;
    m_pins = 16'h0000;
    rd_chk("R7 edge wins over clear", 8'h18);

    // R10 direction and data-in
    bus_wr(8'h34, 16'h00FF);
    chk("R10 direction port", pin_dir, 16'h00FF);
    pin_step(16'h5A00);
    rd_chk("R10 data in", 8'h2C);

    // R11 system words and unmapped reads
    bus_wr(8'h10, 16'h0014);
    rd_chk("R11 sysconfig", 8'h10);
    rd_chk("R11 sysstatus", 8'h14);
    rd_chk("R11 alias reads zero", 8'hDC);
    rd_chk("R11 unmapped reads zero", 8'h7C);

    // Constrained random mix
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(9) < 4) begin
        pin_step(16'($urandom));
      end else begin
        bus_wr(wr_addrs[$urandom_range(14)], 16'($urandom));
      end
      @(negedge clk);
      port_chk("R3/R8/R9/R10 random");
      rd_chk("R4/R5/R6/R7/R11 random read", rd_addrs[$urandom_range(13)]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule